// File: doc/BRIEF.md
# Synchronous Burst Access Sequencer

This block is the device-side sequencer for a synchronous burst memory port. A single 16-bit configuration word selects the operating mode, the initial latency count and type, the polarity and lead timing of the WAIT handshake, and the burst length and wrap behaviour. The word is loaded through a side-band cycle. That cycle has chip enable low, the address strobe low, the configuration enable high and write enable low. The word travels on the low address bits, and the register select sits on address bits [19:18].

After an ordinary address strobe, the sequencer counts the initial latency and holds WAIT asserted. It then raises data-valid and steps a column address through the burst. The address either wraps inside the aligned burst window or runs linearly. Every setting is decoded live from the stored word. Taking chip enable high ends any access at once.

Top module: `burst_seq`

## Requirements
- R1: After reset the configuration word is 0x9D1F. The block is therefore in asynchronous mode and starts no burst. WAIT idles low because it is active-high, and config_error is low.
- R2: A configuration cycle (ce_n=0, adv_n=0, cfg_en=1, we_n=0) loads addr[15:0] only when addr[19:18]=2'b10. The selects 2'b00 and 2'b01 leave the word unchanged.
- R3: While word bit 15 is 1 (asynchronous), data_valid never rises. While it is 0, an address strobe with cfg_en=0 starts an access.
- R4: With bit 14 = 1 (fixed latency), the first data_valid cycle comes exactly N clocks after the strobe edge. N is the code in bits [13:11]. refresh_busy has no effect in this mode.
- R5: With bit 14 = 0 (variable latency), the latency is N when refresh_busy is low at the strobe and 2N when it is high.
- R6: Bits [2:0] set the burst length: 1=4, 2=8, 3=16, 4=32 words. data_valid stays high for exactly that many cycles and then falls.
- R7: With bit 3 = 0, col_addr steps by one and wraps inside the aligned window of the burst length. With bit 3 = 1 it steps linearly. The first data cycle shows the strobed address.
- R8: Burst code 7 is continuous: data goes on linearly until ce_n goes high, and data_valid is low the cycle after.
- R9: Bit 10 gives the WAIT active level: 1 means active-high, 0 means active-low.
- R10: With bit 8 = 0, WAIT is active in every latency cycle. With bit 8 = 1, it drops one cycle before the first data cycle. WAIT is inactive whenever data_valid is high.
- R11: A latency code of 0, 1 or 7, or a burst code other than 1 to 4 or 7, raises config_error. The access then runs as a 4-word burst with latency 3.
- R12: While ce_n is high, WAIT sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| cfg_en | input | 1 | Configuration-register enable |
| we_n | input | 1 | Write enable, active low |
| addr | input | 22 | Address bus; carries the word and select in configuration cycles |
| refresh_busy | input | 1 | Internal refresh in progress, sampled at the strobe |
| data_valid | output | 1 | High in each data beat |
| wait_o | output | 1 | WAIT handshake at the configured polarity |
| col_addr | output | 22 | Current burst column address |
| config_error | output | 1 | Reserved latency or burst code present |

## Verification
The last latency cycle is the point where two functions collide. WAIT release, governed by the lead-timing bit, and the first data beat with its address must line up in that cycle. A doubled variable latency moves that cycle out. A second collision is a chip-enable release landing in the same cycle as a continuous burst beat. The bench sweeps every legal latency code, both latency types, refresh_busy at both levels, all burst codes, both wrap modes and both WAIT polarities and timings. In every cycle it compares WAIT, data_valid and col_addr against cycle indices computed arithmetically from the strobe edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int LAT_W  = 4;
    localparam int BEAT_W = 6;

    typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA} seq_st_e;

    typedef struct packed {
        logic              sync;      // burst mode enabled
        logic              fixed;     // fixed latency type
        logic [LAT_W-1:0]  lat;       // effective latency count
        logic              pol;       // WAIT active level
        logic              early;     // WAIT drops one cycle ahead of data
        logic              wrap;      // wrap inside burst window
        logic              cont;      // continuous burst
        logic [BEAT_W-1:0] last_beat; // burst length minus one, also wrap mask
        logic              err;       // reserved code present
    } cfg_t;
endpackage

// File: rtl/burst_seq_cfg.sv
module burst_seq_cfg
    import burst_seq_pkg::*;
#(
    parameter int          CW       = 16,
    parameter logic [15:0] RST_WORD = 16'h9D1F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_word,
    output cfg_t          cfg
);
    logic [CW-1:0] word_d, word_q;
    logic [2:0]    lat_code, len_code;
    logic          lat_ok, len_ok;
    logic          unused_bits;

    always_comb begin
        word_d = wr_en ? wr_word : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= RST_WORD;
        else        word_q <= word_d;
    end

    assign unused_bits = &{1'b0, word_q[9], word_q[7:4]};

    always_comb begin
        lat_code      = word_q[13:11];
        len_code      = word_q[2:0];
        lat_ok        = (lat_code >= 3'd2) && (lat_code <= 3'd6);
        len_ok        = ((len_code >= 3'd1) && (len_code <= 3'd4)) || (len_code == 3'd7);
        cfg.sync      = ~word_q[15];
        cfg.fixed     = word_q[14];
        cfg.pol       = word_q[10];
        cfg.early     = word_q[8];
        cfg.wrap      = ~word_q[3];
        cfg.err       = ~(lat_ok & len_ok);
        cfg.lat       = cfg.err ? LAT_W'(3) : LAT_W'(lat_code);
        cfg.cont      = ~cfg.err && (len_code == 3'd7);
        if (cfg.err || cfg.cont)
            cfg.last_beat = BEAT_W'(3);
        else
            cfg.last_beat = BEAT_W'((4 << (len_code - 3'd1)) - 1);
    end

    p_reset_word_r1: assert property (@(posedge clk) $rose(rst_n) |-> word_q == RST_WORD);
    p_hold_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(word_q));
endmodule

// File: rtl/burst_seq_addr.sv
module burst_seq_addr
    import burst_seq_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic [AW-1:0]     cur,
    input  logic [BEAT_W-1:0] mask,
    input  logic              wrap,
    output logic [AW-1:0]     nxt
);
    localparam int PAD = AW - BEAT_W;
    logic [AW-1:0] wide_mask, inc;

    always_comb begin
        wide_mask = {{PAD{1'b0}}, mask};
        inc       = cur + AW'(1);
        nxt       = wrap ? ((cur & ~wide_mask) | (inc & wide_mask)) : inc;
    end
endmodule

// File: rtl/burst_seq_wait.sv
module burst_seq_wait (
    input  logic ce_n,
    input  logic in_lat,
    input  logic lat_last,
    input  logic early,
    input  logic pol,
    output logic wait_o
);
    logic active;

    always_comb begin
        active = in_lat && !(early && lat_last);
        wait_o = (!ce_n && active) ? pol : ~pol;
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int AW     = 22,
    parameter int CW     = 16,
    parameter int SEL_LO = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          cfg_en,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          refresh_busy,
    output logic          data_valid,
    output logic          wait_o,
    output logic [AW-1:0] col_addr,
    output logic          config_error
);
    localparam logic [1:0] SEL_BUS_CFG = 2'b10;

    typedef struct packed {
        seq_st_e           st;
        logic [LAT_W-1:0]  cnt;
        logic [BEAT_W-1:0] beat;
        logic [AW-1:0]     addr;
    } seq_t;

    seq_t          r_d, r_q;
    cfg_t          cfg;
    logic          cfg_cycle, cfg_wr, start;
    logic [LAT_W-1:0] lat_tot;
    logic [AW-1:0] addr_nxt;

    assign cfg_cycle = !ce_n && !adv_n && cfg_en;
    assign cfg_wr    = cfg_cycle && !we_n && (addr[SEL_LO+1:SEL_LO] == SEL_BUS_CFG);
    assign start     = !ce_n && !adv_n && !cfg_en && cfg.sync;

    burst_seq_cfg #(.CW(CW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_word (addr[CW-1:0]),
        .cfg     (cfg)
    );

    burst_seq_addr #(.AW(AW)) u_addr (
        .cur  (r_q.addr),
        .mask (cfg.last_beat),
        .wrap (cfg.wrap && !cfg.cont),
        .nxt  (addr_nxt)
    );

    burst_seq_wait u_wait (
        .ce_n     (ce_n),
        .in_lat   (r_q.st == ST_LAT),
        .lat_last (r_q.cnt == '0),
        .early    (cfg.early),
        .pol      (cfg.pol),
        .wait_o   (wait_o)
    );

    always_comb begin
        lat_tot = (refresh_busy && !cfg.fixed) ? {cfg.lat[LAT_W-2:0], 1'b0} : cfg.lat;
        r_d     = r_q;
        if (ce_n || cfg_cycle) begin
            r_d.st = ST_IDLE;
        end else if (start) begin
            r_d.st   = ST_LAT;
            r_d.cnt  = lat_tot - LAT_W'(1);
            r_d.beat = '0;
            r_d.addr = addr;
        end else begin
            case (r_q.st)
                ST_LAT: begin
                    if (r_q.cnt == '0) r_d.st  = ST_DATA;
                    else               r_d.cnt = r_q.cnt - LAT_W'(1);
                end
                ST_DATA: begin
                    if (!cfg.cont && r_q.beat == cfg.last_beat) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.beat = r_q.beat + BEAT_W'(1);
                        r_d.addr = addr_nxt;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, cnt: '0, beat: '0, addr: '0};
        else        r_q <= r_d;
    end

    assign data_valid   = (r_q.st == ST_DATA);
    assign col_addr     = r_q.addr;
    assign config_error = cfg.err;

    p_async_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.sync |-> !data_valid);
    p_ce_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !data_valid);
    p_wait_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> wait_o == ~cfg.pol);
    p_wait_off_in_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !ce_n) |-> wait_o == ~cfg.pol);
    p_wrap_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid) && cfg.wrap && !cfg.cont)
        |-> (col_addr[AW-1:BEAT_W] == $past(col_addr[AW-1:BEAT_W])));
    p_linear_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid) && (!cfg.wrap || cfg.cont))
        |-> col_addr == $past(col_addr) + AW'(1));
endmodule

// File: tb/burst_seq_test.sv
module burst_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        cfg_en = 1'b0;
    logic        we_n = 1'b1;
    logic [21:0] addr = '0;
    logic        refresh_busy = 1'b0;
    logic        data_valid, wait_o, config_error;
    logic [21:0] col_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    burst_seq uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .cfg_en(cfg_en),
        .we_n(we_n), .addr(addr), .refresh_busy(refresh_busy),
        .data_valid(data_valid), .wait_o(wait_o), .col_addr(col_addr),
        .config_error(config_error)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] word, input logic [1:0] sel);
        @(negedge clk);
        ce_n = 0; adv_n = 0; cfg_en = 1; we_n = 0;
        addr = {2'b00, sel, 2'b00, word};
        @(negedge clk);
        ce_n = 1; adv_n = 1; cfg_en = 0; we_n = 1;
    endtask

    function automatic logic [15:0] mk_word(bit fx, int lat, bit pol, bit wc, bit nw, int lc);
        return {1'b0, fx, 3'(lat), pol, 1'b0, wc, 2'b00, 2'b01, nw, 3'(lc)};
    endfunction

    // Runs one access and checks every cycle from the strobe edge onward.
    task automatic access(input int L, input bit busy, input bit fixed, input bit pol,
                          input bit wc, input bit nw, input bit cont, input int len,
                          input logic [21:0] start, input string tag);
        int ltot, span;
        logic [21:0] m;
        ltot = (busy && !fixed) ? 2 * L : L;
        span = cont ? 40 : len;
        m    = 22'(len - 1);
        @(negedge clk);
        ce_n = 0; adv_n = 0; addr = start; refresh_busy = busy;
        @(negedge clk);
        adv_n = 1; refresh_busy = 0; addr = '0;
        for (int i = 0; i < ltot + span + 2; i++) begin
            bit exp_dv, exp_act, ok;
            logic [21:0] exp_a;
            exp_dv  = (i >= ltot) && (cont || i < ltot + len);
            exp_act = wc ? (i < ltot - 1) : (i < ltot);
            exp_a   = '0;
            if (exp_dv) begin
                if (nw || cont) exp_a = start + 22'(i - ltot);
                else exp_a = (start & ~m) | ((start + 22'(i - ltot)) & m);
            end
            ok = (data_valid == exp_dv) && (wait_o == (exp_act ? pol : !pol))
                 && (!exp_dv || col_addr == exp_a);
            chk(ok, tag, $sformatf("cycle %0d dv/wait/addr", i),
                {data_valid, wait_o, col_addr}, {exp_dv, (exp_act ? pol : !pol), exp_a});
            if (cont && i == ltot + span - 1) begin
                ce_n = 1;   // R8: release chip enable mid-burst
                #1;
                chk(wait_o == !pol, "R12", "wait inactive with ce_n high", wait_o, !pol);
                @(negedge clk);
                chk(!data_valid, "R8", "continuous burst stops", data_valid, 0);
                break;
            end
            @(negedge clk);
        end
        ce_n = 1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset word decodes to async, active-high WAIT, no error
        chk(data_valid == 0, "R1", "dv after reset", data_valid, 0);
        chk(wait_o == 0, "R1", "wait idle level", wait_o, 0);
        chk(config_error == 0, "R1", "no error at reset", config_error, 0);
        // R3: strobe in async mode starts nothing
        @(negedge clk); ce_n = 0; adv_n = 0; addr = 22'h40;
        @(negedge clk); adv_n = 1;
        for (int i = 0; i < 20; i++) begin
            chk(data_valid == 0, "R3", "no burst in async mode", data_valid, 0);
            @(negedge clk);
        end
        ce_n = 1;

        // R2: selects 00 and 01 do not touch the word
        cfg_write(mk_word(1, 3, 1, 0, 0, 1), 2'b10);
        cfg_write(16'h9D1F, 2'b00);
        cfg_write(16'h9D1F, 2'b01);
        access(3, 0, 1, 1, 0, 0, 0, 4, 22'h105, "R2");
        // R3: selecting async through 10 halts bursts again
        cfg_write(16'h9D1F, 2'b10);
        @(negedge clk); ce_n = 0; adv_n = 0; addr = 22'h10;
        @(negedge clk); adv_n = 1;
        for (int i = 0; i < 12; i++) begin
            chk(data_valid == 0, "R3", "async after rewrite", data_valid, 0);
            @(negedge clk);
        end
        ce_n = 1;

        // R4 R5 R6 R7 R8 R9 R10: full sweep of legal settings
        k = 0;
        for (int lat = 2; lat <= 6; lat++)
        for (int fx = 0; fx < 2; fx++)
        for (int busy = 0; busy < 2; busy++)
        for (int li = 0; li < 5; li++)
        for (int nw = 0; nw < 2; nw++)
        for (int pw = 0; pw < 4; pw++) begin
            int lc, len;
            lc  = (li == 4) ? 7 : li + 1;
            len = (li == 4) ? 0 : (4 << li);
            k++;
            cfg_write(mk_word(fx[0], lat, pw[0], pw[1], nw[0], lc), 2'b10);
            @(negedge clk);
            chk(config_error == 0, "R11", "legal code no error", config_error, 0);
            access(lat, busy[0], fx[0], pw[0], pw[1], nw[0], li == 4, len,
                   22'h2A0 + 22'((k * 13) % 64), "R4/R5/R6/R7/R9/R10");
        end

        // R11: reserved latency code 0 and reserved burst code 5
        cfg_write(mk_word(1, 0, 1, 0, 0, 2), 2'b10);
        @(negedge clk);
        chk(config_error == 1, "R11", "reserved latency flagged", config_error, 1);
        access(3, 0, 1, 1, 0, 0, 0, 4, 22'h3, "R11");
        cfg_write(mk_word(1, 5, 0, 1, 0, 5), 2'b10);
        @(negedge clk);
        chk(config_error == 1, "R11", "reserved length flagged", config_error, 1);
        access(3, 0, 1, 0, 1, 0, 0, 4, 22'h1E, "R11");
        cfg_write(mk_word(0, 7, 1, 0, 1, 3), 2'b10);
        @(negedge clk);
        chk(config_error == 1, "R11", "latency code 7 flagged", config_error, 1);
        access(3, 1, 0, 1, 0, 1, 0, 4, 22'h7, "R11");

        done = 1;
        finish_run();
    end
endmodule